// File: doc/BRIEF.md
# Two-Level Translation Table Walker

This block resolves a virtual address that missed in a translation cache by searching a two-level table in memory. A request carries the virtual address, the access kind (read or write), the privilege mode and which of the two translation units (instruction side or data side) raised it. The walker picks the root pointer for the mode and fetches a segment descriptor. It then fetches a page descriptor. Both fetches go over a 32-bit memory port with a ready handshake. The walker checks validity and privilege at each level and builds a combined write-protection flag. On success it writes the page descriptor back with its usage bits updated.

When the page descriptor passes its checks, the walker emits a refill record for the page cache. This happens even if the access later fails as a write to a protected page. Faults load a per-unit status register and a per-unit fault address register, and return the other unit's status to success. A one-cycle fault pulse is given to the processor's exception logic, alongside the completion pulse.

The controller moves through these states. ST_IDLE goes to ST_SEG_RD when a request is accepted. ST_SEG_RD goes to ST_SEG_CHK on a memory ready. ST_SEG_CHK goes to ST_PG_RD if the segment descriptor passes, or to ST_REPORT on a fault. ST_PG_RD goes to ST_PG_CHK on a memory ready. ST_PG_CHK goes to ST_PG_WB if the page descriptor passes and the write check passes, or to ST_REPORT on a fault. ST_PG_WB goes to ST_REPORT on a memory ready. ST_REPORT always returns to ST_IDLE.

Top module: `pgwalk_top`

## Requirements
- R1: The segment descriptor is read from {root[31:12], 12'h000} + vaddr[31:22]*4. The page descriptor is read from {sd[31:12], 12'h000} + vaddr[21:12]*4. The memory address is held steady until mem_ready.
- R2: The root pointer is root_super when req_super is 1 and root_user otherwise. It is sampled when the request is accepted.
- R3: A segment descriptor with bit 0 (valid) clear faults with code 3. The unit's status register then reads code<<16 (code in bits 18:16, all other bits 0). Its fault address becomes the segment descriptor's physical address.
- R4: A page descriptor with bit 0 clear faults with code 4, and the fault address becomes the page descriptor's physical address.
- R5: In user mode, a descriptor with bit 8 (supervisor-only) set faults with code 5, with the address of that descriptor. The segment level is checked before the page level. Supervisor mode is allowed through such descriptors.
- R6: The protection flag is segment bit 2 OR page bit 2. A write with this flag set faults with code 6 and clears the fault address to 0. A read with this flag set succeeds.
- R7: On success the page descriptor is written back to its own address with bit 3 (used) set, and with bit 4 (modified) also set for a write. No memory write happens on any fault.
- R8: Once the page descriptor passes its validity and privilege checks, one fill_valid pulse carries: fill_vtag = vaddr[31:12], fill_ptag = pd[31:12], fill_ro = the protection flag, fill_super = mode, fill_used and fill_mod. This pulse comes before the write check and is still given on a code-6 fault, with fill_used=0 and fill_mod=0.
- R9: On a fault by unit req_side (0 instruction, 1 data), the other unit's status register becomes 0 and its fault address is kept. A successful walk changes neither unit's registers.
- R10: req_ready is high only when idle. done is a one-cycle pulse at the end of each walk. fault is high only together with done, and only for a faulted walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Walk request |
| req_ready | output | 1 | Walker idle, request accepted when both high |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | 1 for write access |
| req_super | input | 1 | 1 for supervisor mode |
| req_side | input | 1 | Requesting unit: 0 instruction, 1 data |
| root_super | input | 32 | Supervisor root pointer |
| root_user | input | 32 | User root pointer |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with mem_ready |
| mem_ready | input | 1 | Memory access completes |
| done | output | 1 | Walk finished pulse |
| fault | output | 1 | Walk faulted pulse |
| fill_valid | output | 1 | Refill record valid |
| fill_vtag | output | 20 | Virtual page number |
| fill_ptag | output | 20 | Physical page number |
| fill_ro | output | 1 | Combined write protection |
| fill_super | output | 1 | Entry belongs to supervisor mode |
| fill_used | output | 1 | Entry used flag |
| fill_mod | output | 1 | Entry modified flag |
| status_i | output | 32 | Instruction unit fault status |
| status_d | output | 32 | Data unit fault status |
| faddr_i | output | 32 | Instruction unit fault address |
| faddr_d | output | 32 | Data unit fault address |

## Verification
The hardest situation to reach is a walk that passes every descriptor check and only then fails the write check. That walk must still give a refill record while leaving memory untouched, and its fault address must be zero even though two descriptors were read. The stimulus builds tables in which the protection flag comes from the segment level in one case and from the page level in another, then runs both a write and a read to the same page. Sibling clearing is checked by letting one unit fault, then faulting the other unit and checking that the first unit's address survives while its status returns to zero. Memory latency is varied between walks, so that the held address and the ready timing are exercised.

// File: rtl/pgwalk_pkg.sv
package pgwalk_pkg;
    typedef enum logic [2:0] {
        ST_IDLE, ST_SEG_RD, ST_SEG_CHK, ST_PG_RD, ST_PG_CHK, ST_PG_WB, ST_REPORT
    } walk_state_t;

    localparam logic [2:0] CODE_OK   = 3'd0;
    localparam logic [2:0] CODE_SEG  = 3'd3;
    localparam logic [2:0] CODE_PAGE = 3'd4;
    localparam logic [2:0] CODE_PRIV = 3'd5;
    localparam logic [2:0] CODE_WP   = 3'd6;

    localparam int BIT_VALID = 0;
    localparam int BIT_RO    = 2;
    localparam int BIT_USED  = 3;
    localparam int BIT_MOD   = 4;
    localparam int BIT_SUPER = 8;
    localparam int STAT_LSB  = 16;
endpackage

// File: rtl/pgwalk_addr.sv
module pgwalk_addr #(
    parameter int VA_W      = 32,
    parameter int SEG_W     = 10,
    parameter int PG_W      = 10,
    parameter int OFF_W     = 12,
    parameter int DESC_LOG2 = 2
) (
    input  logic [VA_W-OFF_W-1:0] vtag,
    input  logic [VA_W-OFF_W-1:0] seg_base,
    input  logic [VA_W-OFF_W-1:0] pg_base,
    output logic [VA_W-1:0]       seg_ptr,
    output logic [VA_W-1:0]       pg_ptr
);
    localparam int TAG_W   = VA_W - OFF_W;
    localparam int SEG_PAD = VA_W - SEG_W - DESC_LOG2;
    localparam int PG_PAD  = VA_W - PG_W - DESC_LOG2;

    logic [SEG_W-1:0] seg_idx;
    logic [PG_W-1:0]  pg_idx;

    // Upper field of the tag selects the segment, lower field the page
    assign seg_idx = vtag[TAG_W-1 -: SEG_W];
    assign pg_idx  = vtag[PG_W-1:0];

    assign seg_ptr = {seg_base, {OFF_W{1'b0}}}
                   + {{SEG_PAD{1'b0}}, seg_idx, {DESC_LOG2{1'b0}}};
    assign pg_ptr  = {pg_base, {OFF_W{1'b0}}}
                   + {{PG_PAD{1'b0}}, pg_idx, {DESC_LOG2{1'b0}}};
endmodule

// File: rtl/pgwalk_fault_regs.sv
module pgwalk_fault_regs
    import pgwalk_pkg::*;
#(
    parameter int VA_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic            side,
    input  logic [2:0]      code,
    input  logic [VA_W-1:0] addr,
    output logic [VA_W-1:0] status_i,
    output logic [VA_W-1:0] status_d,
    output logic [VA_W-1:0] faddr_i,
    output logic [VA_W-1:0] faddr_d
);
    logic [VA_W-1:0] stat_word;

    always_comb begin
        stat_word = '0;
        stat_word[STAT_LSB +: 3] = code;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_i <= '0;
            status_d <= '0;
            faddr_i  <= '0;
            faddr_d  <= '0;
        end else if (load) begin
            if (side) begin
                status_d <= stat_word;
                faddr_d  <= addr;
                status_i <= '0;
            end else begin
                status_i <= stat_word;
                faddr_i  <= addr;
                status_d <= '0;
            end
        end
    end

    // R9: the sibling unit returns to success on every fault
    p_sibling_d_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !side) |=> (status_d == '0));
    p_sibling_i_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (load && side) |=> (status_i == '0));
    // R9: the sibling's fault address is kept
    p_sibling_addr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (load && side) |=> $stable(faddr_i));
    // R9: registers only change on a fault load
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> ($stable(status_i) && $stable(status_d)));
endmodule

// File: rtl/pgwalk_fsm.sv
module pgwalk_fsm
    import pgwalk_pkg::*;
#(
    parameter int VA_W  = 32,
    parameter int OFF_W = 12
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic [VA_W-1:0]       req_vaddr,
    input  logic                  req_write,
    input  logic                  req_super,
    input  logic                  req_side,
    input  logic [VA_W-1:0]       root_sel,
    input  logic [VA_W-1:0]       seg_ptr,
    input  logic [VA_W-1:0]       pg_ptr,
    output logic [VA_W-OFF_W-1:0] vtag,
    output logic [VA_W-OFF_W-1:0] seg_base,
    output logic [VA_W-OFF_W-1:0] pg_base,
    output logic                  mem_req,
    output logic                  mem_we,
    output logic [VA_W-1:0]       mem_addr,
    output logic [VA_W-1:0]       mem_wdata,
    input  logic [VA_W-1:0]       mem_rdata,
    input  logic                  mem_ready,
    output logic                  done,
    output logic                  fault,
    output logic                  fill_valid,
    output logic [VA_W-OFF_W-1:0] fill_ptag,
    output logic                  fill_ro,
    output logic                  fill_super,
    output logic                  fill_used,
    output logic                  fill_mod,
    output logic                  flt_load,
    output logic                  flt_side,
    output logic [2:0]            flt_code,
    output logic [VA_W-1:0]       flt_addr
);
    localparam int TAG_W = VA_W - OFF_W;

    walk_state_t state, nstate;

    logic [TAG_W-1:0] va_tag_q;
    logic [TAG_W-1:0] root_q;
    logic             wr_q, su_q, side_q;
    logic [TAG_W-1:0] sd_base_q;
    logic             sd_v_q, sd_ro_q, sd_so_q;
    logic [VA_W-1:0]  pd_q;
    logic [2:0]       code_q;

    logic seg_bad, seg_priv, pg_bad, pg_priv, prot, wp_hit;

    assign vtag     = va_tag_q;
    assign seg_base = root_q;
    assign pg_base  = sd_base_q;

    assign seg_bad  = !sd_v_q;
    assign seg_priv = sd_so_q && !su_q;
    assign pg_bad   = !pd_q[BIT_VALID];
    assign pg_priv  = pd_q[BIT_SUPER] && !su_q;
    assign prot     = sd_ro_q | pd_q[BIT_RO];
    assign wp_hit   = wr_q && prot;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nstate;
    end

    // Next state
    always_comb begin
        nstate = state;
        unique case (state)
            ST_IDLE:    if (req_valid) nstate = ST_SEG_RD;
            ST_SEG_RD:  if (mem_ready) nstate = ST_SEG_CHK;
            ST_SEG_CHK: nstate = (seg_bad || seg_priv) ? ST_REPORT : ST_PG_RD;
            ST_PG_RD:   if (mem_ready) nstate = ST_PG_CHK;
            ST_PG_CHK:  nstate = (pg_bad || pg_priv || wp_hit) ? ST_REPORT : ST_PG_WB;
            ST_PG_WB:   if (mem_ready) nstate = ST_REPORT;
            ST_REPORT:  nstate = ST_IDLE;
            default:    nstate = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        req_ready  = 1'b0;
        mem_req    = 1'b0;
        mem_we     = 1'b0;
        mem_addr   = '0;
        mem_wdata  = '0;
        done       = 1'b0;
        fault      = 1'b0;
        fill_valid = 1'b0;
        flt_load   = 1'b0;
        flt_code   = CODE_OK;
        flt_addr   = '0;
        unique case (state)
            ST_IDLE: req_ready = 1'b1;
            ST_SEG_RD: begin
                mem_req  = 1'b1;
                mem_addr = seg_ptr;
            end
            ST_SEG_CHK: begin
                if (seg_bad) begin
                    flt_load = 1'b1;
                    flt_code = CODE_SEG;
                    flt_addr = seg_ptr;
                end else if (seg_priv) begin
                    flt_load = 1'b1;
                    flt_code = CODE_PRIV;
                    flt_addr = seg_ptr;
                end
            end
            ST_PG_RD: begin
                mem_req  = 1'b1;
                mem_addr = pg_ptr;
            end
            ST_PG_CHK: begin
                if (pg_bad) begin
                    flt_load = 1'b1;
                    flt_code = CODE_PAGE;
                    flt_addr = pg_ptr;
                end else if (pg_priv) begin
                    flt_load = 1'b1;
                    flt_code = CODE_PRIV;
                    flt_addr = pg_ptr;
                end else begin
                    // refill precedes the protection check
                    fill_valid = 1'b1;
                    if (wp_hit) begin
                        flt_load = 1'b1;
                        flt_code = CODE_WP;
                        flt_addr = '0;
                    end
                end
            end
            ST_PG_WB: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = pg_ptr;
                mem_wdata = pd_q;
                mem_wdata[BIT_USED] = 1'b1;
                if (wr_q) mem_wdata[BIT_MOD] = 1'b1;
            end
            ST_REPORT: begin
                done  = 1'b1;
                fault = (code_q != CODE_OK);
            end
            default: ;
        endcase
    end

    assign flt_side   = side_q;
    assign fill_ptag  = pd_q[VA_W-1:OFF_W];
    assign fill_ro    = prot;
    assign fill_super = su_q;
    assign fill_used  = !wp_hit;
    assign fill_mod   = wr_q && !wp_hit;

    // Walk context and captured descriptors
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            va_tag_q  <= '0;
            root_q    <= '0;
            wr_q      <= 1'b0;
            su_q      <= 1'b0;
            side_q    <= 1'b0;
            sd_base_q <= '0;
            sd_v_q    <= 1'b0;
            sd_ro_q   <= 1'b0;
            sd_so_q   <= 1'b0;
            pd_q      <= '0;
            code_q    <= CODE_OK;
        end else begin
            if (state == ST_IDLE && req_valid) begin
                va_tag_q <= req_vaddr[VA_W-1:OFF_W];
                root_q   <= root_sel[VA_W-1:OFF_W];
                wr_q     <= req_write;
                su_q     <= req_super;
                side_q   <= req_side;
                code_q   <= CODE_OK;
            end
            if (state == ST_SEG_RD && mem_ready) begin
                sd_base_q <= mem_rdata[VA_W-1:OFF_W];
                sd_v_q    <= mem_rdata[BIT_VALID];
                sd_ro_q   <= mem_rdata[BIT_RO];
                sd_so_q   <= mem_rdata[BIT_SUPER];
            end
            if (state == ST_PG_RD && mem_ready) pd_q <= mem_rdata;
            if (flt_load) code_q <= flt_code;
        end
    end

    // R10: completion is a single-cycle pulse
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R10: fault only accompanies completion
    p_fault_with_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> done);
    // R10: no new request accepted while busy
    p_ready_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && req_valid) |=> !req_ready);
    // R1: address held while waiting for memory
    p_addr_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr)));
    // R7: write-back only after a fill with no fault
    p_wb_after_fill_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we) |-> $past(fill_valid && !flt_load));
    // R8: a fill never comes with a validity or privilege fault
    p_fill_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid && flt_load) |-> (flt_code == CODE_WP));
endmodule

// File: rtl/pgwalk_top.sv
module pgwalk_top #(
    parameter int VA_W  = 32,
    parameter int SEG_W = 10,
    parameter int PG_W  = 10,
    parameter int OFF_W = 12
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic [VA_W-1:0]       req_vaddr,
    input  logic                  req_write,
    input  logic                  req_super,
    input  logic                  req_side,
    input  logic [VA_W-1:0]       root_super,
    input  logic [VA_W-1:0]       root_user,
    output logic                  mem_req,
    output logic                  mem_we,
    output logic [VA_W-1:0]       mem_addr,
    output logic [VA_W-1:0]       mem_wdata,
    input  logic [VA_W-1:0]       mem_rdata,
    input  logic                  mem_ready,
    output logic                  done,
    output logic                  fault,
    output logic                  fill_valid,
    output logic [VA_W-OFF_W-1:0] fill_vtag,
    output logic [VA_W-OFF_W-1:0] fill_ptag,
    output logic                  fill_ro,
    output logic                  fill_super,
    output logic                  fill_used,
    output logic                  fill_mod,
    output logic [VA_W-1:0]       status_i,
    output logic [VA_W-1:0]       status_d,
    output logic [VA_W-1:0]       faddr_i,
    output logic [VA_W-1:0]       faddr_d
);
    localparam int TAG_W = VA_W - OFF_W;

    logic [VA_W-1:0]  root_sel, seg_ptr, pg_ptr, flt_addr;
    logic [TAG_W-1:0] vtag, seg_base, pg_base;
    logic             flt_load, flt_side;
    logic [2:0]       flt_code;

    assign root_sel  = req_super ? root_super : root_user;
    assign fill_vtag = vtag;

    pgwalk_addr #(.VA_W(VA_W), .SEG_W(SEG_W), .PG_W(PG_W), .OFF_W(OFF_W)) u_addr (
        .vtag(vtag), .seg_base(seg_base), .pg_base(pg_base),
        .seg_ptr(seg_ptr), .pg_ptr(pg_ptr)
    );

    pgwalk_fsm #(.VA_W(VA_W), .OFF_W(OFF_W)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .req_write(req_write), .req_super(req_super), .req_side(req_side),
        .root_sel(root_sel), .seg_ptr(seg_ptr), .pg_ptr(pg_ptr),
        .vtag(vtag), .seg_base(seg_base), .pg_base(pg_base),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
        .done(done), .fault(fault),
        .fill_valid(fill_valid), .fill_ptag(fill_ptag), .fill_ro(fill_ro),
        .fill_super(fill_super), .fill_used(fill_used), .fill_mod(fill_mod),
        .flt_load(flt_load), .flt_side(flt_side), .flt_code(flt_code),
        .flt_addr(flt_addr)
    );

    pgwalk_fault_regs #(.VA_W(VA_W)) u_fregs (
        .clk(clk), .rst_n(rst_n), .load(flt_load), .side(flt_side),
        .code(flt_code), .addr(flt_addr),
        .status_i(status_i), .status_d(status_d),
        .faddr_i(faddr_i), .faddr_d(faddr_d)
    );
endmodule

// File: tb/pgwalk_top_bench.sv
`timescale 1ns/1ps
module pgwalk_top_bench;
    logic clk = 0;
    logic rst_n = 0;
    always #2.5 clk = ~clk;

    logic        req_valid = 0, req_write = 0, req_super = 0, req_side = 0;
    logic [31:0] req_vaddr = 0;
    logic [31:0] root_super = 32'h0001_0000, root_user = 32'h0002_0000;
    logic        req_ready, mem_req, mem_we, done, fault;
    logic [31:0] mem_addr, mem_wdata, status_i, status_d, faddr_i, faddr_d;
    logic [31:0] mem_rdata = 0;
    logic        mem_ready = 0;
    logic        fill_valid, fill_ro, fill_super, fill_used, fill_mod;
    logic [19:0] fill_vtag, fill_ptag;

    pgwalk_top u_pgwalk_top (.*);

    typedef struct {
        logic [2:0]  code;
        logic [31:0] st_i, st_d, fa_i, fa_d;
        logic        has_fill;
        logic [19:0] vtag, ptag;
        logic        ro, su, used, md;
        logic        has_wb;
        logic [31:0] wb_addr, wb_val;
    } exp_t;

    exp_t sb[$];
    logic [31:0] mem_m [logic [31:0]];
    int n_chk = 0, n_fail = 0, lat = 0, wait_cnt = 0;
    logic [31:0] m_st [2];
    logic [31:0] m_fa [2];

    // captures for the current walk
    logic        got_fill, got_wb;
    int          n_fill, n_wb;
    logic [19:0] c_vtag, c_ptag;
    logic        c_ro, c_su, c_used, c_md;
    logic [31:0] c_wa, c_wv;

    function automatic logic [31:0] rd(logic [31:0] a);
        return mem_m.exists(a) ? mem_m[a] : 32'h0;
    endfunction

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // memory model: ready after lat idle cycles, one-cycle pulse
    always @(negedge clk) begin
        if (mem_ready) mem_ready = 0;
        else if (mem_req) begin
            if (wait_cnt >= lat) begin
                mem_ready = 1;
                mem_rdata = rd(mem_addr);
                wait_cnt = 0;
            end else wait_cnt++;
        end
    end

    always @(posedge clk) begin
        if (mem_req && mem_we && mem_ready) begin
            mem_m[mem_addr] = mem_wdata;
            got_wb = 1; n_wb++;
            c_wa = mem_addr; c_wv = mem_wdata;
        end
    end

    // monitor: capture refill and compare at completion
    always @(negedge clk) begin
        if (rst_n && fill_valid) begin
            got_fill = 1; n_fill++;
            c_vtag = fill_vtag; c_ptag = fill_ptag; c_ro = fill_ro;
            c_su = fill_super; c_used = fill_used; c_md = fill_mod;
        end
        if (rst_n && done) begin
            exp_t e;
            if (sb.size() == 0) begin
                chk("R10", "unexpected done", 1, 0);
            end else begin
                e = sb.pop_front();
                chk("R10", "fault flag", {31'b0, fault}, {31'b0, e.code != 0});
                chk("R10", "ready low at done", {31'b0, req_ready}, 0);
                chk("R3", "status_i", status_i, e.st_i);
                chk("R3", "status_d", status_d, e.st_d);
                chk("R9", "faddr_i", faddr_i, e.fa_i);
                chk("R9", "faddr_d", faddr_d, e.fa_d);
                chk("R8", "fill count", n_fill, {31'b0, e.has_fill});
                if (e.has_fill && got_fill) begin
                    chk("R8", "fill vtag", {12'b0, c_vtag}, {12'b0, e.vtag});
                    chk("R8", "fill ptag", {12'b0, c_ptag}, {12'b0, e.ptag});
                    chk("R6", "fill ro", {31'b0, c_ro}, {31'b0, e.ro});
                    chk("R8", "fill super", {31'b0, c_su}, {31'b0, e.su});
                    chk("R8", "fill used", {31'b0, c_used}, {31'b0, e.used});
                    chk("R8", "fill mod", {31'b0, c_md}, {31'b0, e.md});
                end
                chk("R7", "writeback count", n_wb, {31'b0, e.has_wb});
                if (e.has_wb && got_wb) begin
                    chk("R7", "wb addr", c_wa, e.wb_addr);
                    chk("R7", "wb value", c_wv, e.wb_val);
                end
            end
        end
    end

    // driver: compute expectation from the tables, push, then issue
    task automatic walk(logic [31:0] va, logic wr, logic su, logic sd_side);
        exp_t e;
        logic [31:0] root, sa, sd, pa, pd, fa;
        logic ro;
        e.code = 0; e.has_fill = 0; e.has_wb = 0; fa = 0;
        e.vtag = va[31:12]; e.ptag = 0; e.ro = 0; e.su = su; e.used = 0; e.md = 0;
        e.wb_addr = 0; e.wb_val = 0;
        root = su ? root_super : root_user;
        sa = {root[31:12], 12'h0} + {20'b0, va[31:22], 2'b00};
        sd = rd(sa);
        if (!sd[0]) begin e.code = 3; fa = sa; end
        else if (sd[8] && !su) begin e.code = 5; fa = sa; end
        else begin
            pa = {sd[31:12], 12'h0} + {20'b0, va[21:12], 2'b00};
            pd = rd(pa);
            if (!pd[0]) begin e.code = 4; fa = pa; end
            else if (pd[8] && !su) begin e.code = 5; fa = pa; end
            else begin
                ro = sd[2] | pd[2];
                e.has_fill = 1; e.ptag = pd[31:12]; e.ro = ro;
                if (wr && ro) begin e.code = 6; fa = 0; end
                else begin
                    e.used = 1; e.md = wr; e.has_wb = 1; e.wb_addr = pa;
                    e.wb_val = pd | 32'h8 | (wr ? 32'h10 : 32'h0);
                end
            end
        end
        if (e.code != 0) begin
            m_st[sd_side] = {13'b0, e.code, 16'b0};
            m_st[!sd_side] = 0;
            m_fa[sd_side] = fa;
        end
        e.st_i = m_st[0]; e.st_d = m_st[1]; e.fa_i = m_fa[0]; e.fa_d = m_fa[1];
        sb.push_back(e);
        while (!req_ready) @(negedge clk);
        got_fill = 0; got_wb = 0; n_fill = 0; n_wb = 0;
        req_vaddr = va; req_write = wr; req_super = su; req_side = sd_side;
        req_valid = 1;
        @(negedge clk);
        req_valid = 0;
        while (sb.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
        $finish;
    end

    initial begin
        m_st[0] = 0; m_st[1] = 0; m_fa[0] = 0; m_fa[1] = 0;
        // supervisor tables
        mem_m[32'h0001_0004] = 32'h0003_0001;
        mem_m[32'h0003_000C] = 32'h0050_0001;
        mem_m[32'h0001_000C] = 32'h0005_0101;   // supervisor-only segment
        mem_m[32'h0005_0000] = 32'h0070_0101;   // supervisor-only page
        mem_m[32'h0001_0FFC] = 32'h000D_0001;   // last segment slot
        mem_m[32'h000D_0FFC] = 32'h00E0_0001;   // last page slot
        // user tables
        mem_m[32'h0002_0004] = 32'h0004_0001;
        mem_m[32'h0004_000C] = 32'h0060_0001;
        mem_m[32'h0002_000C] = 32'h0005_0101;
        mem_m[32'h0002_0010] = 32'h0008_0001;
        mem_m[32'h0008_0000] = 32'h0090_0101;
        mem_m[32'h0002_0014] = 32'h0009_0005;   // read-only segment
        mem_m[32'h0009_0000] = 32'h00A0_0001;
        mem_m[32'h0002_0018] = 32'h000B_0001;
        mem_m[32'h000B_0008] = 32'h00C0_0005;   // read-only page

        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // reset state
        chk("R10", "reset ready", {31'b0, req_ready}, 1);
        chk("R10", "reset done", {31'b0, done}, 0);
        chk("R3", "reset status_i", status_i, 0);
        chk("R9", "reset faddr_d", faddr_d, 0);

        lat = 0;
        walk(32'h0040_3123, 0, 1, 0);  // R2 supervisor root, read success
        walk(32'h0040_3000, 1, 0, 1);  // R2 user root, write success, R7 modified
        lat = 2;
        walk(32'h0080_0000, 0, 0, 1);  // R3 segment fault on data unit
        walk(32'h0040_5000, 0, 1, 0);  // R4 page fault, R9 sibling cleared
        walk(32'h00C0_0000, 0, 0, 0);  // R5 supervisor-only segment in user mode
        lat = 1;
        walk(32'h00C0_0000, 0, 1, 1);  // R5 supervisor passes supervisor-only levels
        walk(32'h0100_0000, 0, 0, 1);  // R5 supervisor-only page in user mode
        walk(32'h0140_0000, 1, 0, 0);  // R6 write to read-only segment, R8 fill kept
        walk(32'h0140_0000, 0, 0, 0);  // R6 read of read-only succeeds
        lat = 3;
        walk(32'h0180_2000, 1, 0, 1);  // R6 write to read-only page
        walk(32'hFFFF_FABC, 1, 1, 0);  // R1 last segment and page slots
        walk(32'h0040_3123, 1, 1, 1);  // R7 write-back again after used bit set
        walk(32'h0080_0000, 0, 0, 0);  // R9 fault on instruction side clears data side

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule